// File: doc/BRIEF.md
# Ternary Recirculating-Loop Register

This block stores `NTRIT` balanced-ternary digits (trits), each taking the value -1, 0 or +1. No trit sits in a static latch. Each one circulates through a ring of `LOOP_STAGES` quarter-cycle pipeline registers, and the ring's last stage is the visible output. Every trit cell has its own two-valued control input and its own three-valued data input. A single min/max rule, built from ternary majority functions, decides what enters the ring: with control at +1 the data value is written, and with control at -1 the current value goes round the ring again. In this block a read and a hold are the same operation.

An external sequencer drives the timing with a one-hot zone enable, one bit per ring stage, rotating 0 → 1 → 2 → 3. All cells share this enable. Inputs are sampled only in zone 0. The output changes only in the last zone, so a write shows up one full rotation after the inputs were presented. Cycles in which no enable bit is set stall the ring without any loss of data. Two flag vectors report, for each trit, an illegal code and a control/data combination that breaks the rules.

Top module: `tloop_reg`

## Requirements
- R1: Each trit is 2 bits at bit position [2i+1:2i]. The code 2'b11 means -1, 2'b00 means 0 and 2'b01 means +1. The output never carries the code 2'b10.
- R2: A synchronous reset loads 0 into every ring stage, so the output reads all 2'b00 after the first reset edge.
- R3: With control 2'b11 (-1) and data 2'b11 (-1) in a zone-0 cycle, a trit re-enters the ring unchanged and keeps reappearing at the output on later rotations.
- R4: With control 2'b01 (+1) in a zone-0 cycle, the trit's data value enters the ring. It appears on the output at the end of the same rotation, on the edge where the last zone bit is set.
- R5: The output changes only on clock edges where the last zone-enable bit is high. Cycles with no enable bit set change nothing.
- R6: Control and data inputs presented outside zone 0 are ignored.
- R7: Cells are independent. Within one rotation some trits may be written while others hold.
- R8: Control -1 with data other than -1 stores max(data, current value) and raises that trit's rule flag during the zone-0 cycle.
- R9: Data code 2'b10 is read as 0 and a control code other than 2'b11 or 2'b01 is read as -1. Either case raises that trit's code flag during the zone-0 cycle.
- R10: Both flag vectors stay low in every cycle in which zone-enable bit 0 is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| zone_en | input | LOOP_STAGES | One-hot ring-stage enable from the sequencer; bit 0 samples the inputs, the top bit updates the output |
| w_i | input | 2*NTRIT | Per-trit control, 2'b11 = hold/read, 2'b01 = write |
| x_i | input | 2*NTRIT | Per-trit data trit |
| q_o | output | 2*NTRIT | Stored trits (ring tail) |
| err_code_o | output | NTRIT | Illegal code on a trit's data or control |
| err_rule_o | output | NTRIT | Control -1 with data other than -1 |

## Verification
Two things can happen in the same zone-0 cycle: a trit can be written while a neighbour holds, and a flag can be raised while the trit still updates under the rule that applies. Mixed rotations provoke both, with per-trit control vectors that combine write, hold, rule breaking and illegal codes. The scoreboard judges each case against the trit values and flag bits that the requirements predict. Between the enabled phases, the bench drives illegal data and write controls, and it inserts stall cycles, to show that inputs outside zone 0 and idle cycles leave the output and the flags untouched.

// File: rtl/tloop_pkg.sv
package tloop_pkg;
  typedef logic [1:0]        trit_t;
  typedef logic signed [1:0] tval_t;

  localparam trit_t T_NEG  = 2'b11;
  localparam trit_t T_ZERO = 2'b00;
  localparam trit_t T_POS  = 2'b01;
  localparam trit_t T_BAD  = 2'b10;

  localparam tval_t V_NEG = -2'sd1;
  localparam tval_t V_POS = 2'sd1;

  function automatic tval_t t_val(input trit_t c);
    case (c)
      T_NEG:   t_val = V_NEG;
      T_POS:   t_val = V_POS;
      default: t_val = 2'sd0;
    endcase
  endfunction

  function automatic trit_t t_code(input tval_t v);
    if (v == V_NEG)      t_code = T_NEG;
    else if (v == V_POS) t_code = T_POS;
    else                 t_code = T_ZERO;
  endfunction

  function automatic tval_t t_min(input tval_t a, input tval_t b);
    t_min = (a < b) ? a : b;
  endfunction

  function automatic tval_t t_max(input tval_t a, input tval_t b);
    t_max = (a > b) ? a : b;
  endfunction

  function automatic tval_t t_neg(input tval_t a);
    t_neg = -a;
  endfunction

  // ternary majority: max of pairwise mins
  function automatic tval_t t_maj(input tval_t a, input tval_t b, input tval_t c);
    t_maj = t_max(t_max(t_min(a, b), t_min(b, c)), t_min(a, c));
  endfunction

  function automatic logic ctl_legal(input trit_t c);
    ctl_legal = (c == T_NEG) || (c == T_POS);
  endfunction
endpackage

// File: rtl/tloop_next.sv
module tloop_next
  import tloop_pkg::*;
(
  input  trit_t w_i,
  input  trit_t x_i,
  input  trit_t q_i,
  output trit_t nxt_o,
  output logic  bad_code_o,
  output logic  rule_o
);
  tval_t w_eff, x_v, q_v, inner, outer;

  always_comb begin
    // an unknown control code is treated as hold (-1)
    w_eff = ctl_legal(w_i) ? t_val(w_i) : V_NEG;
    x_v   = t_val(x_i);
    q_v   = t_val(q_i);
    // AND of negated control with current value: majority with -1 pinned
    inner = t_maj(t_neg(w_eff), V_NEG, q_v);
    // OR of data with that result: majority with +1 pinned
    outer = t_maj(x_v, V_POS, inner);
    nxt_o = t_code(outer);
  end

  assign bad_code_o = (x_i == T_BAD) || !ctl_legal(w_i);
  assign rule_o     = (w_i == T_NEG) && (x_i != T_NEG);
endmodule

// File: rtl/tloop_stage.sv
module tloop_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)     q_o <= '0;
    else if (en) q_o <= d_i;
  end
endmodule

// File: rtl/tloop_reg.sv
module tloop_reg
  import tloop_pkg::*;
#(
  parameter int NTRIT       = 8,
  parameter int LOOP_STAGES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LOOP_STAGES-1:0]   zone_en,
  input  logic [2*NTRIT-1:0]       w_i,
  input  logic [2*NTRIT-1:0]       x_i,
  output logic [2*NTRIT-1:0]       q_o,
  output logic [NTRIT-1:0]         err_code_o,
  output logic [NTRIT-1:0]         err_rule_o
);
  localparam int W    = 2 * NTRIT;
  localparam int LAST = LOOP_STAGES - 1;

  logic [W-1:0] ring [LOOP_STAGES];
  logic [W-1:0] nxt_vec;
  logic [W-1:0] loop_head;
  logic [W-1:0] loop_tail;
  logic         sample_tick;
  logic         commit_tick;

  assign sample_tick = zone_en[0];
  assign commit_tick = zone_en[LAST];
  assign loop_head   = ring[0];
  assign loop_tail   = ring[LAST];

  genvar i, s;
  generate
    for (i = 0; i < NTRIT; i++) begin : g_cell
      logic bad_code, rule_brk;
      tloop_next u_next (
        .w_i        (w_i[2*i +: 2]),
        .x_i        (x_i[2*i +: 2]),
        .q_i        (loop_tail[2*i +: 2]),
        .nxt_o      (nxt_vec[2*i +: 2]),
        .bad_code_o (bad_code),
        .rule_o     (rule_brk)
      );
      assign err_code_o[i] = sample_tick & bad_code;
      assign err_rule_o[i] = sample_tick & rule_brk;
    end

    for (s = 0; s < LOOP_STAGES; s++) begin : g_ring
      if (s == 0) begin : g_head
        tloop_stage #(.W(W)) u_stg (
          .clk(clk), .rst(rst), .en(zone_en[s]),
          .d_i(nxt_vec), .q_o(ring[s])
        );
      end else begin : g_body
        tloop_stage #(.W(W)) u_stg (
          .clk(clk), .rst(rst), .en(zone_en[s]),
          .d_i(ring[s-1]), .q_o(ring[s])
        );
      end
    end
  endgenerate

  assign q_o = loop_tail;
endmodule

// File: rtl/tloop_reg_chk.sv
module tloop_reg_chk #(
  parameter int NTRIT       = 8,
  parameter int LOOP_STAGES = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LOOP_STAGES-1:0] zone_en,
  input logic [2*NTRIT-1:0]     w_i,
  input logic [2*NTRIT-1:0]     x_i,
  input logic [2*NTRIT-1:0]     q_o,
  input logic [NTRIT-1:0]       err_code_o,
  input logic [NTRIT-1:0]       err_rule_o,
  input logic [2*NTRIT-1:0]     loop_head
);
  localparam int LAST = LOOP_STAGES - 1;

  logic hold_all, write_all;
  always_comb begin
    hold_all  = 1'b1;
    write_all = 1'b1;
    for (int i = 0; i < NTRIT; i++) begin
      if (w_i[2*i +: 2] != 2'b11 || x_i[2*i +: 2] != 2'b11) hold_all = 1'b0;
      if (w_i[2*i +: 2] != 2'b01 || x_i[2*i +: 2] == 2'b10) write_all = 1'b0;
    end
  end

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (q_o == '0 && loop_head == '0)); // R2

  AST_HOLD_RECIRC: assert property (@(posedge clk) disable iff (rst)
    (zone_en[0] && hold_all) |=> (loop_head == $past(q_o))); // R3

  AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (zone_en[0] && write_all) |=> (loop_head == $past(x_i))); // R4

  AST_OUT_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !zone_en[LAST] |=> $stable(q_o)); // R5

  AST_HEAD_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    !zone_en[0] |=> $stable(loop_head)); // R6

  AST_FLAGS_GATED: assert property (@(posedge clk) disable iff (rst)
    ((|err_code_o) || (|err_rule_o)) |-> zone_en[0]); // R10

  genvar g;
  generate
    for (g = 0; g < NTRIT; g++) begin : g_legal
      AST_NO_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
        q_o[2*g +: 2] != 2'b10); // R1
    end
  endgenerate
endmodule

bind tloop_reg tloop_reg_chk #(.NTRIT(NTRIT), .LOOP_STAGES(LOOP_STAGES)) chk_i (
  .clk(clk), .rst(rst), .zone_en(zone_en), .w_i(w_i), .x_i(x_i), .q_o(q_o),
  .err_code_o(err_code_o), .err_rule_o(err_rule_o), .loop_head(loop_head)
);

// File: tb/tloop_reg_tb_top.sv
`timescale 1ns/1ps
module tloop_reg_tb_top;
  localparam int N = 4;
  localparam int S = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst;
  logic [S-1:0]     zone_en;
  logic [2*N-1:0]   w_i, x_i, q_o;
  logic [N-1:0]     err_code_o, err_rule_o;

  tloop_reg #(.NTRIT(N), .LOOP_STAGES(S)) dut_i (
    .clk(clk), .rst(rst), .zone_en(zone_en), .w_i(w_i), .x_i(x_i),
    .q_o(q_o), .err_code_o(err_code_o), .err_rule_o(err_rule_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int model [N];
  logic [2*N-1:0] cur_q = '0;
  logic [2*N-1:0] exp_q [$];
  string          exp_tag [$];
  logic           last_commit = 1'b0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int dec(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic logic [1:0] enc(input int v);
    if (v > 0) return 2'b01;
    if (v < 0) return 2'b11;
    return 2'b00;
  endfunction

  // monitor: after each commit edge, pop the predicted output
  always @(posedge clk) last_commit <= zone_en[S-1] & ~rst;
  always @(negedge clk) begin
    if (last_commit) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected commit", 16'(q_o), 16'hffff);
      end else begin
        automatic logic [2*N-1:0] e = exp_q.pop_front();
        automatic string t = exp_tag.pop_front();
        chk(t, 16'(q_o), 16'(e));
      end
    end
  end

  // driver: one full rotation; predicted values pushed to the scoreboard
  task automatic op(input logic [2*N-1:0] w, input logic [2*N-1:0] x,
                    input string tag, input int stall);
    logic [N-1:0] ec, er;
    logic [2*N-1:0] nq;
    for (int i = 0; i < N; i++) begin
      automatic logic [1:0] wc = w[2*i +: 2];
      automatic logic [1:0] xc = x[2*i +: 2];
      automatic int xv = dec(xc);
      if (wc == 2'b01) model[i] = xv;
      else model[i] = (xv > model[i]) ? xv : model[i];
      ec[i] = (xc == 2'b10) || !(wc == 2'b11 || wc == 2'b01);
      er[i] = (wc == 2'b11) && (xc != 2'b11);
      nq[2*i +: 2] = enc(model[i]);
    end
    exp_q.push_back(nq);
    exp_tag.push_back({tag, " R1 q_o"});
    @(negedge clk);
    zone_en = 1;
    w_i = w; x_i = x;
    #1;
    chk({tag, " R9 err_code"}, 16'(err_code_o), 16'(ec));
    chk({tag, " R8 err_rule"}, 16'(err_rule_o), 16'(er));
    @(posedge clk);
    for (int k = 1; k < S; k++) begin
      for (int st = 0; st < stall; st++) begin
        @(negedge clk);
        zone_en = '0;
        w_i = {N{2'b01}}; x_i = {N{2'b10}};
        #1 chk({tag, " R5 stall q_o"}, 16'(q_o), 16'(cur_q));
        @(posedge clk);
      end
      @(negedge clk);
      zone_en = S'(1) << k;
      w_i = {N{2'b01}}; x_i = {N{2'b10}};
      #1;
      chk({tag, " R10 err_code off-zone"}, 16'(err_code_o), 16'h0);
      chk({tag, " R6 q_o before commit"}, 16'(q_o), 16'(cur_q));
      @(posedge clk);
    end
    cur_q = nq;
    @(negedge clk);
    zone_en = '0;
    #1;
    chk({tag, " R10 err_rule idle"}, 16'(err_rule_o), 16'h0);
  endtask

  initial begin
    rst = 1'b1; zone_en = '0; w_i = '0; x_i = '0;
    for (int i = 0; i < N; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1 chk("R2 reset q_o", 16'(q_o), 16'h0);

    // cells 3..0 : +1, 0, -1, +1
    op(8'b01_01_01_01, 8'b01_00_11_01, "R4 write mixed", 0);
    op(8'b11_11_11_11, 8'b11_11_11_11, "R3 hold stalled", 2);
    op(8'b11_11_11_11, 8'b11_11_11_11, "R3 hold again", 0);
    op(8'b11_01_11_01, 8'b11_11_11_00, "R7 partial write", 0);
    op(8'b11_11_11_11, 8'b00_01_11_11, "R8 rule max", 1);
    op(8'b01_01_01_01, 8'b10_01_10_11, "R9 bad data", 0);
    op(8'b00_10_01_11, 8'b11_11_01_11, "R9 bad control", 0);

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) model[i] = 0;
    cur_q = '0;
    #1 chk("R2 mid-run reset q_o", 16'(q_o), 16'h0);

    op(8'b01_01_01_01, 8'b01_01_01_01, "R4 write after reset", 1);
    op(8'b11_11_11_11, 8'b11_11_11_11, "R3 hold after write", 0);

    repeat (2) @(negedge clk);
    chk("R5 queue drained", 16'(exp_q.size()), 16'h0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule